// File: doc/BRIEF.md
# Strobed Pointer SRAM Bridge

This block connects a host that can spare only a handful of pins to an external byte-wide static RAM. The host side is an 8-bit data path plus three control lines: a select line that picks between the command register and the data path, a read strobe and a write strobe. Inside the bridge are one 8-bit command register and four 24-bit address pointers. The host loads a pointer one byte at a time. It then switches the command to memory mode and moves bytes to or from the RAM at the address that pointer holds.

The command register picks a pointer and says what a data strobe touches: one byte of that pointer, or the RAM location the pointer addresses. It also holds a post-step code. In pointer-byte mode the step moves the byte selector, so a run of strobes loads or reads a whole pointer without issuing a new command. In memory mode the step moves the pointer itself, so a run of strobes forms a burst. The host data path is split into in, out and output-enable ports. The RAM data path is split the same way, and the pads are expected to sit outside the block.

Top module: `sram_ptr_bridge`

## Requirements
- R1: With select high, a write strobe loads the 8-bit command register and a read strobe returns it, all 8 bits included. Bits 1:0 choose the pointer. Bits 3:2 choose the target: 00, 01 or 10 is pointer byte 0 (low), 1 or 2 (high), and 11 is RAM data. Bits 5:4 are the step code: 01 increments, 10 decrements. Bits 7:6 have no function.
- R2: With select low and a pointer-byte target, a write strobe stores the data byte into that byte of the chosen pointer.
- R3: With select low and a pointer-byte target, a read strobe returns that byte of the chosen pointer.
- R4: A pointer-byte access steps the target field. Increment saturates at 10, so later accesses keep using byte 2. Decrement saturates at 00.
- R5: Step codes 00 and 11 change neither the target field nor any pointer.
- R6: In RAM data mode a write strobe runs one RAM write cycle. Its address is the low 19 bits of the chosen pointer. Write enable is asserted only while chip enable is asserted, output enable is off and the data lines are driven, and the address and data stay stable while write enable is asserted.
- R7: In RAM data mode a read strobe returns the RAM byte at the chosen pointer's address.
- R8: In RAM data mode the step code moves the chosen pointer by one after each strobe, modulo 2^24.
- R9: After reset the command register and all pointers are zero and every RAM control is inactive. The host data path is driven only in response to a read strobe.
- R10: Each strobe causes exactly one action and one step, taken when the strobe is released, however long the strobe was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_cmd_i | input | 1 | High: command register; low: data path access |
| host_rd_i | input | 1 | Host read strobe, active high, asynchronous |
| host_wr_i | input | 1 | Host write strobe, active high, asynchronous |
| host_data_i | input | 8 | Data from the host |
| host_data_o | output | 8 | Data to the host |
| host_data_oe_o | output | 1 | Enable for the host data pads |
| sram_addr_o | output | 19 | RAM address |
| sram_data_i | input | 8 | Data read from the RAM |
| sram_data_o | output | 8 | Data written to the RAM |
| sram_data_oe_o | output | 1 | Enable for the RAM data pads |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |

## Verification
A strobe appears inside the block two clock edges after it changes. Read data for registers is valid one edge after that. RAM read data is valid one edge later again, because the enables are registered first. A write or a step takes effect one edge after the released strobe is seen. A RAM write then needs setup, pulse and hold cycles before the pointer moves. The bench holds each read strobe for seven cycles and samples on the falling clock edge just before release. After each release it waits twelve cycles, so every pointer and RAM update has finished before the next check or access.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLD2 = 2'b11
  } step_e;

  typedef struct packed {
    logic [1:0] spare;
    step_e      step;
    logic [1:0] field;
    logic [1:0] slot;
  } cmd_t;

  localparam logic [1:0] FIELD_MEM = 2'b11;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_PULSE, SQ_HOLD} seq_e;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [WIDTH-1:0]             last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      last_q <= '0;
    end else begin
      pipe_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign fall_o  = last_q & ~pipe_q[STAGES-1];
endmodule

// File: rtl/cmd_reg.sv
`timescale 1ns/1ps
module cmd_reg
  import bridge_pkg::*;
#(
  parameter int PTR_BYTES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       step_field_i,
  output cmd_t       cmd_o
);
  localparam logic [1:0] FIELD_TOP = 2'(PTR_BYTES - 1);

  cmd_t cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (load_i) begin
      cmd_q <= cmd_t'(load_data_i);
    end else if (step_field_i) begin
      case (cmd_q.step)
        STEP_UP:   if (cmd_q.field < FIELD_TOP) cmd_q.field <= cmd_q.field + 2'd1;
        STEP_DOWN: if (cmd_q.field != 2'd0 && cmd_q.field <= FIELD_TOP)
                     cmd_q.field <= cmd_q.field - 2'd1;
        default: ;
      endcase
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/ptr_file.sv
`timescale 1ns/1ps
module ptr_file #(
  parameter int NUM_PTR = 4,
  parameter int PTR_W   = 24,
  localparam int IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
  localparam int BYTES  = PTR_W / 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ld_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [1:0]                    byte_i,
  input  logic [7:0]                    ld_data_i,
  input  logic                          step_i,
  input  logic                          dec_i,
  output logic [NUM_PTR-1:0][PTR_W-1:0] ptr_o
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] q;
    logic [PTR_W-1:0] loaded;
    logic             hit;

    assign hit = (idx_i == IDX_W'(g));

    always_comb begin
      loaded = q;
      for (int b = 0; b < BYTES; b++)
        if (byte_i == 2'(b)) loaded[8*b +: 8] = ld_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= '0;
      else if (ld_i && hit)   q <= loaded;
      else if (step_i && hit) q <= dec_i ? q - PTR_W'(1) : q + PTR_W'(1);
    end

    assign ptr_o[g] = q;
  end
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import bridge_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  localparam int MAX_CYC  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_act_i,
  input  logic       wr_start_i,
  input  logic [7:0] wr_data_i,
  output logic       done_o,
  output logic [7:0] sram_data_o,
  output logic       sram_data_oe_o,
  output logic       sram_ce_no,
  output logic       sram_oe_no,
  output logic       sram_we_no
);
  seq_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       data_q;
  logic             rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      rd_q    <= 1'b0;
    end else begin
      rd_q <= rd_act_i && (state_q == SQ_IDLE) && !wr_start_i;
      case (state_q)
        SQ_IDLE: if (wr_start_i) begin
          state_q <= SQ_SETUP;
          data_q  <= wr_data_i;
          cnt_q   <= '0;
        end
        SQ_SETUP: if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
          state_q <= SQ_PULSE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + CNT_W'(1);
        SQ_PULSE: if (cnt_q == CNT_W'(PULSE_CYC - 1)) begin
          state_q <= SQ_HOLD;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + CNT_W'(1);
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign done_o         = (state_q == SQ_HOLD);
  assign sram_data_o    = data_q;
  assign sram_data_oe_o = (state_q != SQ_IDLE);
  assign sram_we_no     = (state_q != SQ_PULSE);
  assign sram_oe_no     = !rd_q;
  assign sram_ce_no     = !(rd_q || state_q != SQ_IDLE);
endmodule

// File: rtl/sram_ptr_bridge.sv
`timescale 1ns/1ps
module sram_ptr_bridge
  import bridge_pkg::*;
#(
  parameter int NUM_PTR   = 4,
  parameter int PTR_W     = 24,
  parameter int SRAM_AW   = 19,
  parameter int SYNC_STG  = 2,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_sel_cmd_i,
  input  logic               host_rd_i,
  input  logic               host_wr_i,
  input  logic [7:0]         host_data_i,
  output logic [7:0]         host_data_o,
  output logic               host_data_oe_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  input  logic [7:0]         sram_data_i,
  output logic [7:0]         sram_data_o,
  output logic               sram_data_oe_o,
  output logic               sram_ce_no,
  output logic               sram_oe_no,
  output logic               sram_we_no
);
  localparam int PTR_BYTES = PTR_W / 8;
  localparam int IDX_W     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  logic [2:0] lvl, fall;
  logic       rd_lvl, wr_lvl, sel_lvl, rd_fall, wr_fall;

  strobe_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({host_sel_cmd_i, host_wr_i, host_rd_i}),
    .level_o (lvl),
    .fall_o  (fall)
  );

  assign rd_lvl  = lvl[0];
  assign wr_lvl  = lvl[1];
  assign sel_lvl = lvl[2];
  assign rd_fall = fall[0];
  assign wr_fall = fall[1];

  // Capture the select line and write data while a strobe is held.
  logic       sel_q;
  logic [7:0] wdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      if (rd_lvl || wr_lvl) sel_q <= sel_lvl;
      if (wr_lvl) wdata_q <= host_data_i;
    end
  end

  cmd_t cmd;
  logic is_mem, step_any, step_dn;
  logic cmd_load, reg_wr, reg_rd_done, mem_rd_done, mem_wr_start, seq_done;
  logic [1:0] cmd_field;

  assign is_mem       = (cmd.field == FIELD_MEM);
  assign step_dn      = (cmd.step == STEP_DOWN);
  assign step_any     = (cmd.step == STEP_UP) || step_dn;
  assign cmd_load     = wr_fall && sel_q;
  assign reg_wr       = wr_fall && !sel_q && !is_mem;
  assign reg_rd_done  = rd_fall && !sel_q && !is_mem;
  assign mem_rd_done  = rd_fall && !sel_q && is_mem;
  assign mem_wr_start = wr_fall && !sel_q && is_mem;
  assign cmd_field    = cmd.field;

  cmd_reg #(.PTR_BYTES(PTR_BYTES)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (cmd_load),
    .load_data_i  (wdata_q),
    .step_field_i ((reg_wr || reg_rd_done) && step_any),
    .cmd_o        (cmd)
  );

  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_all;
  logic [PTR_W-1:0]              sel_ptr;

  ptr_file #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (reg_wr),
    .idx_i     (cmd.slot[IDX_W-1:0]),
    .byte_i    (cmd.field),
    .ld_data_i (wdata_q),
    .step_i    ((mem_rd_done || seq_done) && step_any),
    .dec_i     (step_dn),
    .ptr_o     (ptr_all)
  );

  assign sel_ptr     = ptr_all[cmd.slot[IDX_W-1:0]];
  assign sram_addr_o = sel_ptr[SRAM_AW-1:0];

  sram_seq #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_act_i       (rd_lvl && !sel_lvl && is_mem),
    .wr_start_i     (mem_wr_start),
    .wr_data_i      (wdata_q),
    .done_o         (seq_done),
    .sram_data_o    (sram_data_o),
    .sram_data_oe_o (sram_data_oe_o),
    .sram_ce_no     (sram_ce_no),
    .sram_oe_no     (sram_oe_no),
    .sram_we_no     (sram_we_no)
  );

  logic [7:0] ptr_byte;
  always_comb begin
    ptr_byte = '0;
    for (int b = 0; b < PTR_BYTES; b++)
      if (cmd.field == 2'(b)) ptr_byte = sel_ptr[8*b +: 8];
  end

  logic [7:0] rdata_q;
  logic       oe_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= rd_lvl;
      if (rd_lvl) rdata_q <= sel_lvl ? 8'(cmd) : (is_mem ? sram_data_i : ptr_byte);
    end
  end

  assign host_data_o    = rdata_q;
  assign host_data_oe_o = oe_q;
endmodule

// File: rtl/sram_ptr_bridge_chk.sv
`timescale 1ns/1ps
module sram_ptr_bridge_chk #(
  parameter int AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] sram_addr_o,
  input logic [7:0]    sram_data_o,
  input logic          sram_data_oe_o,
  input logic          sram_ce_no,
  input logic          sram_oe_no,
  input logic          sram_we_no,
  input logic          cmd_load,
  input logic [1:0]    cmd_field
);
  AST_WE_INSIDE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_data_oe_o && sram_oe_no)); // R6

  AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_data_oe_o && !sram_oe_no)); // R6

  AST_WE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> ($stable(sram_addr_o) && $stable(sram_data_o))); // R6

  AST_WE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> ($past(sram_data_oe_o) && $stable(sram_addr_o))); // R6

  AST_FIELD_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_field) != 2'b11 && !$past(cmd_load)) |-> (cmd_field != 2'b11)); // R4
endmodule

bind sram_ptr_bridge sram_ptr_bridge_chk #(.AW(SRAM_AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sram_addr_o    (sram_addr_o),
  .sram_data_o    (sram_data_o),
  .sram_data_oe_o (sram_data_oe_o),
  .sram_ce_no     (sram_ce_no),
  .sram_oe_no     (sram_oe_no),
  .sram_we_no     (sram_we_no),
  .cmd_load       (cmd_load),
  .cmd_field      (cmd_field)
);

// File: tb/sram_ptr_bridge_bench.sv
`timescale 1ns/1ps
module sram_ptr_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_din = '0;
  logic [7:0]  h_dout;
  logic        h_oe;
  logic [18:0] s_addr;
  logic [7:0]  s_rdata, s_wdata;
  logic        s_doe, s_ce_n, s_oe_n, s_we_n;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sram_ptr_bridge u_sram_ptr_bridge (
    .clk_i (clk), .rst_ni (rst_n),
    .host_sel_cmd_i (h_sel), .host_rd_i (h_rd), .host_wr_i (h_wr),
    .host_data_i (h_din), .host_data_o (h_dout), .host_data_oe_o (h_oe),
    .sram_addr_o (s_addr), .sram_data_i (s_rdata), .sram_data_o (s_wdata),
    .sram_data_oe_o (s_doe), .sram_ce_no (s_ce_n), .sram_oe_no (s_oe_n),
    .sram_we_no (s_we_n)
  );

  // RAM model: sparse, written on the rising edge of write enable.
  logic [7:0] mem [int];
  always @* begin
    s_rdata = 8'h00;
    if (!s_ce_n && !s_oe_n && mem.exists(int'(s_addr))) s_rdata = mem[int'(s_addr)];
  end
  always @(posedge s_we_n) if (s_ce_n === 1'b0) mem[int'(s_addr)] = s_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [1:0] st, input logic [1:0] fld, input logic [1:0] slot);
    return {2'b00, st, fld, slot};
  endfunction

  task automatic hw(input logic sel, input logic [7:0] d);
    @(negedge clk); h_sel = sel; h_din = d;
    repeat (2) @(negedge clk); h_wr = 1'b1;
    repeat (6) @(negedge clk); h_wr = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic hr(input logic sel, input int hold, output logic [7:0] d, output logic oe);
    @(negedge clk); h_sel = sel;
    repeat (2) @(negedge clk); h_rd = 1'b1;
    repeat (hold) @(negedge clk);
    d = h_dout; oe = h_oe; h_rd = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic rd_ptr(input logic [1:0] p, output logic [23:0] v);
    logic [7:0] d; logic oe;
    hw(1'b1, mk(2'b01, 2'b00, p));
    for (int k = 0; k < 3; k++) begin
      hr(1'b0, 7, d, oe);
      v[8*k +: 8] = d;
    end
  endtask

  task automatic set_ptr(input logic [1:0] p, input logic [23:0] v);
    hw(1'b1, mk(2'b01, 2'b00, p));
    for (int k = 0; k < 3; k++) hw(1'b0, v[8*k +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic        oe;
    logic [23:0] v;
    repeat (3) @(negedge clk);
    chk("R9 reset host oe", h_oe, 0);
    chk("R9 reset ram ctl", {s_ce_n, s_oe_n, s_we_n, s_doe}, 4'b1110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hr(1'b1, 7, d, oe);
    chk("R9 reset cmd", d, 8'h00);
    chk("R9 oe during read", oe, 1);
    chk("R9 oe idle", h_oe, 0);
    rd_ptr(2'd3, v);
    chk("R9 reset ptr3", v, 24'h0);

    // R1: command write and readback, spare bits kept
    hw(1'b1, 8'hC5);
    hr(1'b1, 7, d, oe);
    chk("R1 cmd readback", d, 8'hC5);

    // R2 R3 R4: load each pointer with increment, overflow write, read back downward
    for (int p = 0; p < 4; p++) begin
      hw(1'b1, mk(2'b01, 2'b00, 2'(p)));
      for (int k = 0; k < 3; k++) hw(1'b0, 8'(8'h10 * (k + 1) + p));
      hw(1'b0, 8'hEE);
      hr(1'b1, 7, d, oe);
      chk("R4 inc saturates at 2", d, mk(2'b01, 2'b10, 2'(p)));
      hw(1'b1, mk(2'b10, 2'b10, 2'(p)));
      hr(1'b0, 7, d, oe); chk("R2 R4 byte2 overwritten", d, 8'hEE);
      hr(1'b0, 7, d, oe); chk("R3 byte1", d, 8'(8'h20 + p));
      hr(1'b0, 7, d, oe); chk("R3 byte0", d, 8'(8'h10 + p));
      hr(1'b0, 7, d, oe); chk("R4 dec saturates at 0", d, 8'(8'h10 + p));
      hr(1'b1, 7, d, oe);
      chk("R4 field at 0", d, mk(2'b10, 2'b00, 2'(p)));
    end

    // R5: step codes 11 and 00 do not move the field or the pointer
    hw(1'b1, mk(2'b11, 2'b01, 2'd2));
    hw(1'b0, 8'h5A);
    hw(1'b0, 8'h5B);
    hr(1'b1, 7, d, oe);
    chk("R5 field kept", d, mk(2'b11, 2'b01, 2'd2));
    hr(1'b0, 7, d, oe);
    chk("R5 same byte rewritten", d, 8'h5B);
    rd_ptr(2'd2, v);
    chk("R5 ptr2 other bytes", v, 24'hEE5B12);

    // R6 R8: RAM write burst with increment
    set_ptr(2'd1, 24'h000100);
    hw(1'b1, mk(2'b01, 2'b11, 2'd1));
    for (int k = 0; k < 5; k++) hw(1'b0, 8'(8'hA0 + k));
    for (int k = 0; k < 5; k++)
      chk("R6 ram written", mem.exists(32'h100 + k) ? 32'(mem[32'h100 + k]) : 32'hDEAD, 32'(8'hA0 + k));
    rd_ptr(2'd1, v);
    chk("R8 ptr after write burst", v, 24'h000105);

    // R7: read bursts up and down
    set_ptr(2'd1, 24'h000100);
    hw(1'b1, mk(2'b01, 2'b11, 2'd1));
    for (int k = 0; k < 4; k++) begin
      hr(1'b0, 7, d, oe);
      chk("R7 inc burst", d, 8'(8'hA0 + k));
    end
    hw(1'b1, mk(2'b10, 2'b11, 2'd1));
    for (int k = 0; k < 3; k++) begin
      hr(1'b0, 7, d, oe);
      chk("R7 dec burst", d, 8'(8'hA4 - k));
    end
    rd_ptr(2'd1, v);
    chk("R8 ptr after dec burst", v, 24'h000101);

    // R10: one step per strobe even when held long
    hw(1'b1, mk(2'b01, 2'b11, 2'd1));
    hr(1'b0, 40, d, oe);
    chk("R10 long strobe data", d, 8'hA1);
    rd_ptr(2'd1, v);
    chk("R10 single step", v, 24'h000102);

    // R5: step 00 in RAM mode leaves pointer alone
    hw(1'b1, mk(2'b00, 2'b11, 2'd1));
    hr(1'b0, 7, d, oe);
    chk("R5 ram read no step", d, 8'hA2);
    rd_ptr(2'd1, v);
    chk("R5 ptr unchanged", v, 24'h000102);

    // R6 R8: address masking and 24-bit wrap both ways
    set_ptr(2'd3, 24'hFFFFFF);
    hw(1'b1, mk(2'b01, 2'b11, 2'd3));
    hw(1'b0, 8'h77);
    chk("R6 low 19 bits address", mem.exists(32'h7FFFF) ? 32'(mem[32'h7FFFF]) : 32'hDEAD, 32'h77);
    rd_ptr(2'd3, v);
    chk("R8 wrap up", v, 24'h000000);
    hw(1'b1, mk(2'b10, 2'b11, 2'd3));
    hw(1'b0, 8'h66);
    chk("R6 write at zero", mem.exists(0) ? 32'(mem[0]) : 32'hDEAD, 32'h66);
    rd_ptr(2'd3, v);
    chk("R8 wrap down", v, 24'hFFFFFF);
    chk("R9 oe idle end", h_oe, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule